// File: doc/BRIEF.md
# AHB-Lite to APB Bridge with Built-in Peripheral Selector

This block is an AHB-Lite slave that turns each legal word access into one APB transfer on a segment of up to sixteen peripherals. The bridge owns a 64KB window. Bits [15:12] of the captured address pick one of sixteen fixed 4KB slots, and each slot can hold up to 1024 word registers. The same four bits drive the one-hot peripheral select and steer the read data, ready and error return lines back from the chosen slot. No separate multiplexer is needed.

Every AHB-facing output comes straight from a register. Each APB transfer takes one SETUP cycle and then ACCESS cycles that last until the selected slot reports ready. A peripheral error, an access that is not a word access, or a peripheral that stalls for too long each produce the standard two-cycle AHB error response.

Top module: `awb_bridge`

## Requirements
- R1: While reset is asserted, hreadyout_o=1, hresp_o=0 (OKAY), psel_o=0 and penable_o=0.
- R2: If the bridge is not selected, or htrans_i is IDLE (2'b00) or BUSY (2'b01), in a cycle with hready_i=1 and hreadyout_o=1, then the next cycle has hreadyout_o=1, hresp_o=0 and psel_o=0.
- R3: A legal transfer is one with htrans_i[1]=1 (NONSEQ or SEQ), hsize_i=3'b010 and haddr_i[1:0]=0. In the cycle after its address phase, exactly one psel_o bit is high, the bit with index haddr_i[15:12]. In that cycle penable_o=0 and paddr_o=haddr_i[15:0]. Address bits above 15 are ignored.
- R4: Each SETUP cycle is followed by ACCESS cycles (penable_o=1, same psel_o). ACCESS lasts until the selected pready is high, and hreadyout_o stays 0 for the whole APB transfer.
- R5: For a read that completes without error, the cycle after the last ACCESS cycle has hreadyout_o=1 and hresp_o=0. In that cycle hrdata_o holds the selected slot's prdata from the last ACCESS cycle.
- R6: For a write, pwrite_o=1 during SETUP and ACCESS, and pwdata_o carries the hwdata_i of the data phase.
- R7: A pslverr from the selected slot in the completing ACCESS cycle gives the AHB error response. That response is one cycle with hreadyout_o=0, hresp_o=1, then one cycle with hreadyout_o=1, hresp_o=1.
- R8: An active transfer with hsize_i other than 3'b010, or with haddr_i[1:0] not zero, gets the two-cycle error response directly after its address phase. It raises no psel_o bit.
- R9: If the selected pready stays low for MAX_WAIT (default 16) ACCESS cycles, the bridge drops psel_o and gives the two-cycle error response. A pready that arrives in the last allowed cycle still completes normally.
- R10: pready and pslverr inputs of slots that are not selected have no effect on the timing or response of a transfer.
- R11: A new transfer presented in the cycle where hreadyout_o returns to 1 (after an OKAY completion or in the second error cycle) is accepted with no idle cycle between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsel_i | input | 1 | Bridge selected by the AHB decoder |
| haddr_i | input | 32 | AHB address |
| htrans_i | input | 2 | AHB transfer type |
| hwrite_i | input | 1 | AHB write flag |
| hsize_i | input | 3 | AHB transfer size |
| hwdata_i | input | 32 | AHB write data (data phase) |
| hready_i | input | 1 | AHB bus ready |
| hrdata_o | output | 32 | AHB read data |
| hreadyout_o | output | 1 | Slave ready |
| hresp_o | output | 1 | 0 = OKAY, 1 = ERROR |
| paddr_o | output | 16 | APB address within the window |
| psel_o | output | 16 | One-hot peripheral select |
| penable_o | output | 1 | APB access phase |
| pwrite_o | output | 1 | APB write flag |
| pwdata_o | output | 32 | APB write data |
| prdata_i | input | 512 | Read data, slot n at bits [32n+31:32n] |
| pready_i | input | 16 | Ready per slot |
| pslverr_i | input | 16 | Error per slot |

## Verification
The properties assume a single-master segment in which hready_i follows the bridge's own hreadyout_o. They also assume no active transfer is presented while the bridge is still busy. They rely on the master holding hwdata_i steady until the transfer ends. The bench meets these conditions by tying hready_i to hreadyout_o and starting each new address phase only in a cycle where hreadyout_o is high. It keeps hwdata_i fixed from the data phase until completion. The APB model raises ready and error on every unselected slot, so any leak from a wrong slot shows up as wrong timing or a wrong response.

// File: rtl/awb_pkg.sv
package awb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_ERR1,
    ST_ERR2
  } awb_state_e;

  localparam logic [2:0] HSIZE_WORD = 3'b010;
endpackage

// File: rtl/awb_addr_stage.sv
module awb_addr_stage
  import awb_pkg::*;
#(
  parameter int HADDR_W = 32,
  parameter int PADDR_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hsel_i,
  input  logic [HADDR_W-1:0] haddr_i,
  input  logic [1:0]         htrans_i,
  input  logic               hwrite_i,
  input  logic [2:0]         hsize_i,
  input  logic               hready_i,
  input  logic               accept_i,
  output logic               start_o,
  output logic               bad_o,
  output logic [PADDR_W-1:0] paddr_o,
  output logic               pwrite_o
);
  logic xfer, legal;
  logic [PADDR_W-1:0] paddr_q;
  logic pwrite_q;

  assign xfer    = hsel_i & hready_i & htrans_i[1] & accept_i;
  assign legal   = (hsize_i == HSIZE_WORD) && (haddr_i[1:0] == 2'b00);
  assign start_o = xfer & legal;
  assign bad_o   = xfer & ~legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_q  <= '0;
      pwrite_q <= 1'b0;
    end else if (start_o) begin
      paddr_q  <= haddr_i[PADDR_W-1:0];
      pwrite_q <= hwrite_i;
    end
  end

  assign paddr_o  = paddr_q;
  assign pwrite_o = pwrite_q;
endmodule

// File: rtl/awb_slot_mux.sv
module awb_slot_mux #(
  parameter int SLOT_W = 4,
  parameter int DATA_W = 32,
  localparam int NSLOT = 1 << SLOT_W
) (
  input  logic [SLOT_W-1:0]       slot_i,
  input  logic                    active_i,
  input  logic [NSLOT*DATA_W-1:0] prdata_i,
  input  logic [NSLOT-1:0]        pready_i,
  input  logic [NSLOT-1:0]        pslverr_i,
  output logic [NSLOT-1:0]        psel_o,
  output logic [DATA_W-1:0]       prdata_o,
  output logic                    pready_o,
  output logic                    pslverr_o
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_sel
    assign psel_o[g] = active_i && (slot_i == SLOT_W'(g));
  end

  assign prdata_o  = prdata_i[slot_i*DATA_W +: DATA_W];
  assign pready_o  = pready_i[slot_i];
  assign pslverr_o = pslverr_i[slot_i];
endmodule

// File: rtl/awb_ctrl.sv
module awb_ctrl
  import awb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MAX_WAIT = 16,
  localparam int WAIT_W  = $clog2(MAX_WAIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bad_i,
  input  logic              pwrite_i,
  input  logic              pready_i,
  input  logic              pslverr_i,
  input  logic [DATA_W-1:0] prdata_i,
  output logic              accept_o,
  output logic              apb_active_o,
  output logic              penable_o,
  output logic              hreadyout_o,
  output logic              hresp_o,
  output logic [DATA_W-1:0] hrdata_o
);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(MAX_WAIT - 1);

  awb_state_e state_q, state_d;
  logic [WAIT_W-1:0] wait_q;
  logic [DATA_W-1:0] hrdata_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_ERR2: begin
        if (start_i)    state_d = ST_SETUP;
        else if (bad_i) state_d = ST_ERR1;
        else            state_d = ST_IDLE;
      end
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: begin
        if (pready_i)               state_d = pslverr_i ? ST_ERR1 : ST_IDLE;
        else if (wait_q == WAIT_LAST) state_d = ST_ERR1;
      end
      ST_ERR1:   state_d = ST_ERR2;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wait_q   <= '0;
      hrdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SETUP)       wait_q <= '0;
      else if (state_q == ST_ACCESS) wait_q <= wait_q + 1'b1;
      if (state_q == ST_ACCESS && pready_i && !pslverr_i && !pwrite_i)
        hrdata_q <= prdata_i;
    end
  end

  // all AHB-facing outputs are pure state decodes: no input-to-output path
  assign accept_o     = (state_q == ST_IDLE) || (state_q == ST_ERR2);
  assign hreadyout_o  = accept_o;
  assign hresp_o      = (state_q == ST_ERR1) || (state_q == ST_ERR2);
  assign apb_active_o = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
  assign penable_o    = (state_q == ST_ACCESS);
  assign hrdata_o     = hrdata_q;
endmodule

// File: rtl/awb_bridge.sv
module awb_bridge #(
  parameter int HADDR_W  = 32,
  parameter int DATA_W   = 32,
  parameter int SLOT_W   = 4,
  parameter int SLOT_AW  = 12,
  parameter int MAX_WAIT = 16,
  localparam int NSLOT   = 1 << SLOT_W,
  localparam int PADDR_W = SLOT_W + SLOT_AW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hsel_i,
  input  logic [HADDR_W-1:0]      haddr_i,
  input  logic [1:0]              htrans_i,
  input  logic                    hwrite_i,
  input  logic [2:0]              hsize_i,
  input  logic [DATA_W-1:0]       hwdata_i,
  input  logic                    hready_i,
  output logic [DATA_W-1:0]       hrdata_o,
  output logic                    hreadyout_o,
  output logic                    hresp_o,
  output logic [PADDR_W-1:0]      paddr_o,
  output logic [NSLOT-1:0]        psel_o,
  output logic                    penable_o,
  output logic                    pwrite_o,
  output logic [DATA_W-1:0]       pwdata_o,
  input  logic [NSLOT*DATA_W-1:0] prdata_i,
  input  logic [NSLOT-1:0]        pready_i,
  input  logic [NSLOT-1:0]        pslverr_i
);
  logic accept, start, bad, apb_active;
  logic sel_ready, sel_err;
  logic [DATA_W-1:0] sel_rdata;

  awb_addr_stage #(.HADDR_W(HADDR_W), .PADDR_W(PADDR_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hsel_i   (hsel_i),
    .haddr_i  (haddr_i),
    .htrans_i (htrans_i),
    .hwrite_i (hwrite_i),
    .hsize_i  (hsize_i),
    .hready_i (hready_i),
    .accept_i (accept),
    .start_o  (start),
    .bad_o    (bad),
    .paddr_o  (paddr_o),
    .pwrite_o (pwrite_o)
  );

  awb_slot_mux #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_mux (
    .slot_i    (paddr_o[PADDR_W-1 -: SLOT_W]),
    .active_i  (apb_active),
    .prdata_i  (prdata_i),
    .pready_i  (pready_i),
    .pslverr_i (pslverr_i),
    .psel_o    (psel_o),
    .prdata_o  (sel_rdata),
    .pready_o  (sel_ready),
    .pslverr_o (sel_err)
  );

  awb_ctrl #(.DATA_W(DATA_W), .MAX_WAIT(MAX_WAIT)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .bad_i        (bad),
    .pwrite_i     (pwrite_o),
    .pready_i     (sel_ready),
    .pslverr_i    (sel_err),
    .prdata_i     (sel_rdata),
    .accept_o     (accept),
    .apb_active_o (apb_active),
    .penable_o    (penable_o),
    .hreadyout_o  (hreadyout_o),
    .hresp_o      (hresp_o),
    .hrdata_o     (hrdata_o)
  );

  // master holds hwdata while hreadyout_o is low, so it is stable across the APB transfer
  assign pwdata_o = hwdata_i;
endmodule

// File: rtl/awb_bridge_chk.sv
module awb_bridge_chk #(
  parameter int NSLOT    = 16,
  parameter int MAX_WAIT = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hsel_i,
  input logic [1:0]       htrans_i,
  input logic [2:0]       hsize_i,
  input logic             hready_i,
  input logic             hreadyout_o,
  input logic             hresp_o,
  input logic [NSLOT-1:0] psel_o,
  input logic             penable_o
);
  localparam int CW = $clog2(MAX_WAIT + 2);
  logic [CW-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          acc_q <= '0;
    else if (!penable_o)                  acc_q <= '0;
    else if (acc_q != CW'(MAX_WAIT + 1))  acc_q <= acc_q + 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni)
      assert_reset_R1: assert (hreadyout_o && !hresp_o && psel_o == '0 && !penable_o)
        else $error("R1 reset outputs");
    else if (penable_o)
      assert_wait_bound_R9: assert (acc_q < CW'(MAX_WAIT))
        else $error("R9 access too long");
  end

  assert_idle_ok_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!hsel_i || !htrans_i[1]) && hready_i && hreadyout_o) |=> (hreadyout_o && !hresp_o && psel_o == '0));

  assert_onehot_psel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(psel_o));

  assert_setup_access_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o != '0 && !penable_o) |=> (penable_o && psel_o == $past(psel_o)));

  assert_busy_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o != '0) |-> !hreadyout_o);

  assert_enable_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    penable_o |-> (psel_o != '0));

  assert_err_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hresp_o && !hreadyout_o) |=> (hresp_o && hreadyout_o));

  assert_bad_no_apb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsel_i && hready_i && hreadyout_o && htrans_i[1] && hsize_i != 3'b010)
      |=> (psel_o == '0 && hresp_o && !hreadyout_o));
endmodule

bind awb_bridge awb_bridge_chk #(.NSLOT(NSLOT), .MAX_WAIT(MAX_WAIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hsel_i      (hsel_i),
  .htrans_i    (htrans_i),
  .hsize_i     (hsize_i),
  .hready_i    (hready_i),
  .hreadyout_o (hreadyout_o),
  .hresp_o     (hresp_o),
  .psel_o      (psel_o),
  .penable_o   (penable_o)
);

// File: tb/sim_awb_bridge.sv
`timescale 1ns/1ps
module sim_awb_bridge;
  localparam int NS = 16;
  localparam int MW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'b010;
  logic [31:0] hwdata = '0;
  logic        hready;
  logic [31:0] hrdata;
  logic        hreadyout, hresp;
  logic [15:0] paddr;
  logic [NS-1:0] psel;
  logic        penable, pwrite;
  logic [31:0] pwdata;
  logic [NS*32-1:0] prdata;
  logic [NS-1:0] pready, pslverr;

  int wait_cfg = 0;
  logic err_cfg = 1'b0;
  int acc_cnt = 0;

  assign hready = hreadyout;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      prdata[i*32 +: 32] = {8'h5A, 4'(i), 4'h0, paddr};
      pready[i]  = psel[i] ? (acc_cnt >= wait_cfg) : 1'b1;
      pslverr[i] = psel[i] ? err_cfg : 1'b1;
    end
  end

  always @(posedge clk) acc_cnt <= penable ? acc_cnt + 1 : 0;

  awb_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .hsel_i(hsel), .haddr_i(haddr), .htrans_i(htrans),
    .hwrite_i(hwrite), .hsize_i(hsize), .hwdata_i(hwdata), .hready_i(hready),
    .hrdata_o(hrdata), .hreadyout_o(hreadyout), .hresp_o(hresp), .paddr_o(paddr),
    .psel_o(psel), .penable_o(penable), .pwrite_o(pwrite), .pwdata_o(pwdata),
    .prdata_i(prdata), .pready_i(pready), .pslverr_i(pslverr)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  typedef struct {
    logic [31:0] a;
    logic        w;
    logic [31:0] wd;
    logic        err;
    logic        fwd;
    string       tag;
  } item_t;

  item_t q[$];
  logic pend = 1'b0;
  logic prev_rdy = 1'b1, prev_resp = 1'b0;

  // monitor: APB side while pending, AHB completion pops the scoreboard
  always @(negedge clk) begin
    if (rst_n && pend && q.size() > 0) begin
      item_t it;
      it = q[0];
      if (psel != '0) begin
        check(it.fwd, {it.tag, " R8 psel on illegal"}, 32'(psel), 32'h0);
        check(psel == NS'(1) << it.a[15:12], {it.tag, " R3 psel"}, 32'(psel), 32'(NS'(1) << it.a[15:12]));
        check(paddr == it.a[15:0], {it.tag, " R3 paddr"}, 32'(paddr), 32'(it.a[15:0]));
        check(pwrite == it.w, {it.tag, " R6 pwrite"}, 32'(pwrite), 32'(it.w));
        if (it.w) check(pwdata == it.wd, {it.tag, " R6 pwdata"}, pwdata, it.wd);
      end
      if (hreadyout) begin
        void'(q.pop_front());
        pend = 1'b0;
        check(hresp == it.err, {it.tag, " resp"}, 32'(hresp), 32'(it.err));
        if (it.err)
          check(!prev_rdy && prev_resp, {it.tag, " R7 first error cycle"}, {prev_rdy, prev_resp}, 32'h1);
        else if (!it.w)
          check(hrdata == {8'h5A, it.a[15:12], 4'h0, it.a[15:0]}, {it.tag, " R5 rdata"},
                hrdata, {8'h5A, it.a[15:12], 4'h0, it.a[15:0]});
      end
    end
    prev_rdy  = hreadyout;
    prev_resp = hresp;
  end

  // driver: one address phase, data phase held until completion; R11 back-to-back by chaining
  task automatic xfer(input logic [31:0] a, input logic w, input logic [2:0] sz,
                      input logic [31:0] wd, input int wt, input logic se, input string tag);
    item_t it;
    int exp_low, lows;
    logic legal;
    legal = (sz == 3'b010) && (a[1:0] == 2'b00);
    it.a = a; it.w = w; it.wd = wd; it.fwd = legal; it.tag = tag;
    it.err = !legal || (wt >= MW) || se;
    exp_low = !legal ? 1 : (wt >= MW) ? MW + 2 : se ? wt + 3 : wt + 2;
    wait_cfg = wt;
    err_cfg  = se;
    q.push_back(it);
    hsel = 1'b1; haddr = a; htrans = 2'b10; hwrite = w; hsize = sz;
    @(posedge clk);
    pend = 1'b1;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwdata = wd;
    lows = 0;
    while (!hreadyout) begin
      lows++;
      @(negedge clk);
    end
    check(lows == exp_low, {tag, " R4/R9/R10 stall cycles"}, 32'(lows), 32'(exp_low));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(hreadyout && !hresp && psel == '0 && !penable, "R1 reset state",
          {hreadyout, hresp, penable}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: idle, busy, and unselected active
    hsel = 1'b1; htrans = 2'b00; haddr = 32'h0000_3000;
    @(negedge clk);
    check(hreadyout && !hresp && psel == '0, "R2 idle", {hreadyout, hresp}, 32'h2);
    htrans = 2'b01;
    @(negedge clk);
    check(hreadyout && !hresp && psel == '0, "R2 busy", {hreadyout, hresp}, 32'h2);
    hsel = 1'b0; htrans = 2'b10;
    @(negedge clk);
    @(negedge clk);
    check(hreadyout && !hresp && psel == '0, "R2 unselected", 32'(psel), 32'h0);
    htrans = 2'b00;
    @(negedge clk);

    xfer(32'h0000_0000, 1'b0, 3'b010, 32'h0, 0, 1'b0, "R5 read slot0");
    xfer(32'h0000_F004, 1'b0, 3'b010, 32'h0, 2, 1'b0, "R5 read slot15");
    xfer(32'h0000_7FFC, 1'b0, 3'b010, 32'h0, 5, 1'b0, "R10 read slot7 wait5");
    xfer(32'hFFFF_2010, 1'b0, 3'b010, 32'h0, 0, 1'b0, "R3 high bits ignored");
    xfer(32'h0000_3008, 1'b1, 3'b010, 32'hDEAD_BEEF, 0, 1'b0, "R6 write slot3");
    xfer(32'h0000_9100, 1'b1, 3'b010, 32'h1234_5678, 3, 1'b0, "R6 write slot9");
    xfer(32'h0000_4000, 1'b0, 3'b010, 32'h0, 1, 1'b1, "R7 read slverr");
    xfer(32'h0000_5004, 1'b1, 3'b010, 32'hA5A5_A5A5, 0, 1'b1, "R7 write slverr");
    xfer(32'h0000_1000, 1'b0, 3'b001, 32'h0, 0, 1'b0, "R8 halfword");
    xfer(32'h0000_1002, 1'b0, 3'b010, 32'h0, 0, 1'b0, "R8 unaligned");
    xfer(32'h0000_1003, 1'b1, 3'b000, 32'h55, 0, 1'b0, "R8 byte write");
    xfer(32'h0000_6000, 1'b0, 3'b010, 32'h0, MW - 1, 1'b0, "R9 last wait ok");
    xfer(32'h0000_6004, 1'b0, 3'b010, 32'h0, MW, 1'b0, "R9 timeout");
    xfer(32'h0000_A00C, 1'b0, 3'b010, 32'h0, 0, 1'b0, "R11 after error");

    @(negedge clk);
    check(q.size() == 0 && hreadyout && !hresp && psel == '0, "R2 final idle",
          32'(q.size()), 32'h0);
    finish_run();
  end
endmodule